// File: doc/BRIEF.md
# Bus-Master Burst Byte-Enable Generator

This block turns one memory region, given as a start address, a byte count and a transfer direction, into a stream of DWord beats for a bus master. Each beat carries an address, a 4-bit byte-enable mask and a flag that marks the final beat of a burst. Bursts are cut so that none crosses a 32-byte cache line. The first burst runs from the start address up to the next line boundary.

The direction changes how the start address and the enables are treated. A memory read always fetches whole DWords, so address bit 1 is dropped and every lane is enabled. A memory write honours a start address on a 16-bit boundary: the first beat leaves the low word disabled. Lanes past the end of the valid data are also disabled. A remaining-byte counter falls by the number of bytes each accepted beat consumes. When it reaches zero the block goes idle and pulses a completion flag.

Top module: `bm_be_gen`

## Requirements
- R1: After reset, beat_valid_o, busy_o and done_o are all 0.
- R2: start_i is taken only when busy_o is 0. A start_i raised while busy changes neither the current beat nor the region being walked.
- R3: For a read (wr_i = 0), every beat address has bits [1:0] equal to 0 and every beat has beat_be_o = 4'b1111, including the final beat.
- R4: For a write (wr_i = 1), address bit 1 is kept on the first beat. When it is set, beat_be_o[1:0] is 0 on that beat. Later beats have address bits [1:0] = 0.
- R5: For a write, beat_be_o bit i enables the byte at offset i of the beat's DWord. The enabled lanes are exactly the valid bytes, and the lanes after the last valid byte are 0.
- R6: Each accepted write beat lowers the remaining count by the number of enabled lanes. Each accepted read beat lowers it by the smaller of 4 and the remaining count. The region ends with the beat that brings it to zero.
- R7: count_i = 0 stands for 2^CNT_W bytes.
- R8: beat_last_o is 1 exactly on a beat that is the last DWord of a 32-byte line or the final beat of the region. Successive beats advance by one DWord.
- R9: While beat_valid_o is 1 and beat_ready_i is 0, the beat's address, enables and last flag hold. A beat is consumed on each clock edge with beat_valid_o and beat_ready_i both 1.
- R10: The first beat is valid in the cycle after start_i is taken. done_o is 1 for exactly the one cycle after the final beat is accepted, and in that cycle busy_o and beat_valid_o are 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a region (taken when idle) |
| addr_i | input | ADDR_W | Region start byte address |
| count_i | input | CNT_W | Region byte count, 0 = 2^CNT_W |
| wr_i | input | 1 | 1 = memory write, 0 = memory read |
| beat_valid_o | output | 1 | Beat presented |
| beat_ready_i | input | 1 | Beat accepted by the bus side |
| beat_addr_o | output | ADDR_W | Beat byte address |
| beat_be_o | output | 4 | Byte enables, bit i = byte offset i |
| beat_last_o | output | 1 | Final beat of the current burst |
| busy_o | output | 1 | Region in progress |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
The first beat of a region appears one edge after start_i is taken. Each further beat appears one edge after the previous beat's handshake. done_o rises one edge after the final handshake and falls at the next edge. The bench drives inputs on the falling edge and samples on the following falling edge, so it sees the registered state left by exactly one rising edge. It keeps an arithmetic model of address, remaining count and lane mask that it advances only on cycles where it drove ready high. Stall cycles must therefore show the same beat again, and the region must end on the very beat the model predicts.

// File: rtl/bm_be_pkg.sv
package bm_be_pkg;
  localparam int unsigned BEAT_BYTES = 4;
  typedef logic [BEAT_BYTES-1:0] be_t;
  typedef logic [2:0] nbytes_t;
endpackage

// File: rtl/bm_be_lane.sv
module bm_be_lane
  import bm_be_pkg::*;
#(
  parameter int unsigned REM_W = 17
) (
  input  logic             wr_i,
  input  logic [1:0]       off_i,
  input  logic [REM_W-1:0] rem_i,
  output be_t              be_o,
  output nbytes_t          nbytes_o
);
  nbytes_t avail;
  nbytes_t n;
  nbytes_t off_ext;

  always_comb begin
    off_ext = {1'b0, off_i};
    avail   = wr_i ? (nbytes_t'(BEAT_BYTES) - off_ext) : nbytes_t'(BEAT_BYTES);
    if (rem_i < REM_W'(avail)) n = rem_i[2:0];
    else                       n = avail;
  end

  assign nbytes_o = n;

  for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
    assign be_o[i] = !wr_i || ((3'(i) >= off_ext) && ((off_ext + n) > 3'(i)));
  end
endmodule

// File: rtl/bm_be_walk.sv
module bm_be_walk
  import bm_be_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned REM_W = CNT_W + 1,
  localparam int unsigned DW_W  = ADDR_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_i,
  input  logic             adv_i,
  input  nbytes_t          nbytes_i,
  output logic             busy_o,
  output logic             wr_o,
  output logic [1:0]       off_o,
  output logic [DW_W-1:0]  dw_o,
  output logic [REM_W-1:0] rem_o,
  output logic             done_o
);
  logic             busy_q, wr_q, done_q;
  logic [1:0]       off_q;
  logic [DW_W-1:0]  dw_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] used;

  assign used = REM_W'(nbytes_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      off_q  <= '0;
      dw_q   <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        wr_q   <= wr_i;
        dw_q   <= addr_i[ADDR_W-1:2];
        off_q  <= wr_i ? {addr_i[1], 1'b0} : 2'b00;  // reads drop bit 1
        rem_q  <= (count_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_i};
      end else if (busy_q && adv_i) begin
        dw_q  <= dw_q + 1'b1;
        off_q <= 2'b00;
        rem_q <= rem_q - used;
        if (rem_q == used) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign wr_o   = wr_q;
  assign off_o  = off_q;
  assign dw_o   = dw_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;
endmodule

// File: rtl/bm_be_gen.sv
module bm_be_gen
  import bm_be_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LINE_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [3:0]        beat_be_o,
  output logic              beat_last_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned REM_W     = CNT_W + 1;
  localparam int unsigned DW_W      = ADDR_W - 2;
  localparam int unsigned LINE_DW_W = $clog2(LINE_BYTES / BEAT_BYTES);

  logic             mode_wr;
  logic [1:0]       off;
  logic [DW_W-1:0]  dw;
  logic [REM_W-1:0] rem;
  be_t              be;
  nbytes_t          nbytes;
  logic             busy;
  logic             adv;

  assign adv = busy && beat_ready_i;

  bm_be_walk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .addr_i   (addr_i),
    .count_i  (count_i),
    .wr_i     (wr_i),
    .adv_i    (adv),
    .nbytes_i (nbytes),
    .busy_o   (busy),
    .wr_o     (mode_wr),
    .off_o    (off),
    .dw_o     (dw),
    .rem_o    (rem),
    .done_o   (done_o)
  );

  bm_be_lane #(.REM_W(REM_W)) i_lane (
    .wr_i     (mode_wr),
    .off_i    (off),
    .rem_i    (rem),
    .be_o     (be),
    .nbytes_o (nbytes)
  );

  assign beat_valid_o = busy;
  assign busy_o       = busy;
  assign beat_addr_o  = {dw, off};
  assign beat_be_o    = be;
  assign beat_last_o  = (&dw[LINE_DW_W-1:0]) || (REM_W'(nbytes) == rem);
endmodule

// File: rtl/bm_be_gen_chk.sv
module bm_be_gen_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LINE_DW_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic [3:0]        beat_be_o,
  input logic              beat_last_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              mode_wr
);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
      && $stable(beat_be_o) && $stable(beat_last_o));

  a_r3_read_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !mode_wr |-> beat_be_o == 4'hf && beat_addr_o[1:0] == 2'b00);

  a_r4_low_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && mode_wr && beat_addr_o[1] |-> beat_be_o[1:0] == 2'b00);

  a_r5_some_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> beat_be_o != 4'h0);

  a_r8_line_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && (&beat_addr_o[LINE_DW_W+1:2]) |-> beat_last_o);

  a_r10_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(beat_valid_o && beat_ready_i && beat_last_o));
endmodule

bind bm_be_gen bm_be_gen_chk #(.ADDR_W(ADDR_W), .LINE_DW_W(LINE_DW_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_addr_o  (beat_addr_o),
  .beat_be_o    (beat_be_o),
  .beat_last_o  (beat_last_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mode_wr      (mode_wr)
);

// File: tb/test_bm_be_gen.sv
module test_bm_be_gen;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic wr_i = 1'b0;
  logic beat_ready_i = 1'b0;
  logic beat_valid_o, beat_last_o, busy_o, done_o;
  logic [ADDR_W-1:0] beat_addr_o;
  logic [3:0] beat_be_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  bm_be_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_bm_be_gen (
    .clk_i, .rst_ni, .start_i, .addr_i, .count_i, .wr_i,
    .beat_valid_o, .beat_ready_i, .beat_addr_o, .beat_be_o, .beat_last_o,
    .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 180000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // count 0 means 2^CNT_W bytes
  task automatic run_region(input logic [ADDR_W-1:0] addr, input int cnt,
                            input bit wr, input int seed, input bit stall_on);
    longint a;
    int rem, k, off, n, be;
    bit rdy, last;
    rem = (cnt == 0) ? (1 << CNT_W) : cnt;
    a = wr ? (addr & ~longint'(1)) : (addr & ~longint'(3));
    @(negedge clk_i);
    start_i = 1'b1; addr_i = addr; count_i = CNT_W'(cnt); wr_i = wr;
    beat_ready_i = 1'b0;
    @(posedge clk_i);
    k = 0;
    while (rem > 0) begin
      @(negedge clk_i);
      rdy = stall_on ? (((k + seed) % 3) != 2) : 1'b1;
      start_i = 1'b0;
      if (!rdy && k < 3) begin
        start_i = 1'b1; addr_i = ~addr; count_i = 5; wr_i = ~wr;  // R2 junk
      end
      k++;
      beat_ready_i = rdy;
      off = int'(a & 3);
      if (wr) begin
        n = (4 - off < rem) ? 4 - off : rem;
        be = ((1 << n) - 1) << off;
      end else begin
        n = (rem < 4) ? rem : 4;
        be = 'hf;
      end
      last = (((a >> 2) & 7) == 7) || (n == rem);
      chk(beat_valid_o == 1'b1, "R10", "beat_valid", beat_valid_o, 1);
      chk(beat_addr_o == ADDR_W'(a), wr ? "R4" : "R3", "addr", beat_addr_o, a);
      chk(beat_be_o == 4'(be), wr ? "R5" : "R3", "be", beat_be_o, be);
      chk(beat_last_o == last, "R8", "last", beat_last_o, last);
      @(posedge clk_i);
      if (rdy) begin  // R9 advance only on handshake
        a = (a & ~longint'(3)) + 4;
        rem -= n;
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
    beat_ready_i = 1'b0;
    chk(done_o == 1'b1, "R10", "done pulse", done_o, 1);
    chk(busy_o == 1'b0 && beat_valid_o == 1'b0, "R6", "idle at count zero",
        {busy_o, beat_valid_o}, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10", "done one cycle", done_o, 0);
  endtask

  initial begin
    #1;
    chk(beat_valid_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1", "reset",
        {beat_valid_o, busy_o, done_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1", "after reset",
        {beat_valid_o, busy_o, done_o}, 0);
    for (int wr = 0; wr < 2; wr++) begin
      for (int lo = 0; lo < 32; lo += 2) begin
        for (int cnt = 1; cnt <= 40; cnt++) begin
          run_region(32'hA000_0000 | (cnt << 8) | lo, cnt, wr[0], cnt % 3, 1'b1);
        end
      end
    end
    run_region(32'h1000_0002, 0, 1'b1, 0, 1'b0);  // R7 write, 2^CNT_W bytes
    run_region(32'h2000_0006, 0, 1'b0, 0, 1'b0);  // R7 read
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule